// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit up-counter and a watchdog counter that take turns owning a single programmable prescaler. A 6-bit mode register picks the division ratio, which of the two counters the prescaler sits in front of, whether the timer counts instruction-cycle ticks or transitions on an external pin, and which transition of that pin counts. When the prescaler serves the timer, its ratio is 2 to 256. When it serves the watchdog, the same codes give 1 to 128.

The watchdog advances on a free-running tick, through the prescaler when it is assigned there. On overflow it emits a one-cycle reset pulse and drops the time-out flag. The clear-watchdog and sleep strobes restart it and raise the flag. A fuse-style option input can keep the watchdog off for good. Software can load the timer through a write port.

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset the counter reads 0, the time-out flag reads 1, the reset pulse is low, and the mode register holds 6'b111111.
- R2: With mode bit 5 = 0 (internal source) and mode bit 3 = 1 (prescaler on the watchdog), every cycle with `cyc_tick` high adds 1 to the counter.
- R3: With mode bit 3 = 0 (prescaler on the timer), the counter advances once per 2^(code+1) source events, where code is mode bits 2..0.
- R4: With mode bit 3 = 1, the watchdog counter advances once per 2^code watchdog ticks.
- R5: With mode bit 5 = 1, the timer counts edges of `ext_pin` after a two-flop synchronizer: rising edges when mode bit 4 = 0, falling edges when it is 1.
- R6: The counter wraps from 8'hFF to 8'h00.
- R7: A counter write loads `cnt_wdata` on the next edge, takes precedence over an increment in the same cycle, and restarts the prescaler when the prescaler is assigned to the timer.
- R8: A `wdt_clr` or `sleep_req` strobe zeroes the watchdog count, sets the time-out flag to 1, and restarts the prescaler when it is assigned to the watchdog.
- R9: When the watchdog counter overflows, `wdt_rst` is high for exactly one cycle and the time-out flag goes to 0.
- R10: With `wdt_en_opt` low, `wdt_rst` never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle tick |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Free-running watchdog tick |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep strobe; also clears the watchdog |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 6 | Mode register write data |
| cnt_we | input | 1 | Counter write enable |
| cnt_wdata | input | 8 | Counter write data |
| wdt_en_opt | input | 1 | Watchdog enable option |
| cnt_value | output | 8 | Current counter value |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| tof_flag | output | 1 | Time-out flag |

## Verification
The bench builds the block with the default 8-bit counter and prescaler widths but with a 4-bit watchdog counter. This brings a watchdog overflow within 16 watchdog ticks at ratio 1 and within 32 ticks at ratio 2. As a result, the overflow pulse, the flag drop and the clear strobe can all be reached in a short run. The timer ratios and the 8-bit wrap are exercised at their real widths.

// File: rtl/tmr_wdog_pkg.sv
// Shared mode-register layout and reset value for the timer/watchdog block.
// Assumes a 6-bit mode word: source, edge, assignment, 3-bit ratio code.
package tmr_wdog_pkg;

    typedef struct packed {
        logic       src_ext;     // bit 5: 1 = external pin edges
        logic       edge_fall;   // bit 4: 1 = falling edges count
        logic       psc_to_wdt;  // bit 3: 1 = prescaler feeds watchdog
        logic [2:0] ratio;       // bits 2..0: ratio code
    } tmr_mode_t;

    localparam int MODE_W = 6;
    localparam logic [MODE_W-1:0] MODE_RST = 6'b111111;

endpackage

// File: rtl/tmr_pin_sync.sv
// Synchronizes the external count pin and produces a one-cycle pulse on
// the selected transition. Assumes STAGES >= 2.
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer and remember the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    // Pick the transition that counts.
    always_comb begin
        if (fall_sel) edge_pulse = prev & ~chain[STAGES-1];
        else          edge_pulse = ~prev & chain[STAGES-1];
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Divides an event stream by a power of two. The divisor is 2^code when
// the prescaler drives the watchdog and 2^(code+1) when it drives the timer.
// Assumes PSC_W >= 2^SEL_W so that the largest limit fits.
module tmr_prescaler #(
    parameter int PSC_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_evt,
    input  logic             clear,
    input  logic [SEL_W-1:0] code,
    input  logic             to_wdt,
    output logic             out_evt
);
    localparam int SH_W = SEL_W + 1;

    logic [PSC_W-1:0] count;
    logic [PSC_W-1:0] limit;
    logic [SH_W-1:0]  shift;

    // Terminal count for the current code and assignment.
    always_comb begin
        shift   = {1'b0, code} + (to_wdt ? SH_W'(0) : SH_W'(1));
        limit   = PSC_W'((33'd1 << shift) - 33'd1);
        out_evt = in_evt && (count == limit);
    end

    // Advance on each input event, restart on terminal count or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (clear)   count <= '0;
        else if (out_evt) count <= '0;
        else if (in_evt)  count <= count + PSC_W'(1);
    end
endmodule

// File: rtl/tmr_wdog_cnt.sv
// Watchdog counter: advances on its tick, overflows into a one-cycle reset
// pulse and a cleared time-out flag. A clear strobe has priority.
module tmr_wdog_cnt #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_opt,
    input  logic tick,
    input  logic clear,
    output logic wdt_rst,
    output logic tof_flag
);
    localparam logic [WDT_W-1:0] WDT_MAX = '1;

    logic [WDT_W-1:0] count;

    // Count, overflow, and clear handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            wdt_rst  <= 1'b0;
            tof_flag <= 1'b1;
        end else begin
            wdt_rst <= 1'b0;
            if (clear) begin
                count    <= '0;
                tof_flag <= 1'b1;
            end else if (!en_opt) begin
                count <= '0;
            end else if (tick) begin
                if (count == WDT_MAX) begin
                    count    <= '0;
                    wdt_rst  <= 1'b1;
                    tof_flag <= 1'b0;
                end else begin
                    count <= count + WDT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tmr_wdog_top.sv
// Timer and watchdog sharing one prescaler. Holds the mode register and
// the timer counter; routes the prescaler to whichever counter owns it.
module tmr_wdog_top
    import tmr_wdog_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PSC_W  = 8,
    parameter int WDT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wdt_tick,
    input  logic              wdt_clr,
    input  logic              sleep_req,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              wdt_en_opt,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              wdt_rst,
    output logic              tof_flag
);
    tmr_mode_t mode;
    logic      pin_evt, tmr_src, psc_in, psc_out, psc_clr;
    logic      tmr_inc, wdt_adv, wdt_kick;

    // Mode register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= tmr_mode_t'(MODE_RST);
        else if (mode_we) mode <= tmr_mode_t'(mode_wdata);
    end

    tmr_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .fall_sel  (mode.edge_fall),
        .edge_pulse(pin_evt)
    );

    // Route sources and strobes according to the prescaler assignment.
    always_comb begin
        wdt_kick = wdt_clr | sleep_req;
        tmr_src  = mode.src_ext ? pin_evt : cyc_tick;
        psc_in   = mode.psc_to_wdt ? wdt_tick : tmr_src;
        psc_clr  = mode.psc_to_wdt ? wdt_kick : cnt_we;
        tmr_inc  = mode.psc_to_wdt ? tmr_src : psc_out;
        wdt_adv  = mode.psc_to_wdt ? psc_out : wdt_tick;
    end

    tmr_prescaler #(.PSC_W(PSC_W), .SEL_W(3)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_evt (psc_in),
        .clear  (psc_clr),
        .code   (mode.ratio),
        .to_wdt (mode.psc_to_wdt),
        .out_evt(psc_out)
    );

    // Timer counter: write wins over increment, wraps at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_value <= '0;
        else if (cnt_we)  cnt_value <= cnt_wdata;
        else if (tmr_inc) cnt_value <= cnt_value + CNT_W'(1);
    end

    tmr_wdog_cnt #(.WDT_W(WDT_W)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_opt  (wdt_en_opt),
        .tick    (wdt_adv),
        .clear   (wdt_kick),
        .wdt_rst (wdt_rst),
        .tof_flag(tof_flag)
    );
endmodule

// File: rtl/tmr_wdog_chk.sv
// Port-level properties of the timer/watchdog block, bound to the top.
module tmr_wdog_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_clr,
    input logic             sleep_req,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             wdt_en_opt,
    input logic [CNT_W-1:0] cnt_value,
    input logic             wdt_rst,
    input logic             tof_flag
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |=> !wdt_rst); // R9
    AST_RST_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |-> !tof_flag); // R9
    AST_CLR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (wdt_clr || sleep_req) |=> (tof_flag && !wdt_rst)); // R8
    AST_OPT_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wdt_en_opt |=> !wdt_rst); // R10
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n) cnt_we |=> (cnt_value == $past(cnt_wdata))); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !cnt_we |=> (cnt_value == $past(cnt_value) || cnt_value == CNT_W'($past(cnt_value) + 1'b1))); // R6
endmodule

bind tmr_wdog_top tmr_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_clr   (wdt_clr),
    .sleep_req (sleep_req),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .wdt_en_opt(wdt_en_opt),
    .cnt_value (cnt_value),
    .wdt_rst   (wdt_rst),
    .tof_flag  (tof_flag)
);

// File: tb/sim_tmr_wdog_top.sv
module sim_tmr_wdog_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDT_BITS   = 4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cyc_tick = 0, ext_pin = 0, wdt_tick = 0, wdt_clr = 0, sleep_req = 0;
    logic       mode_we = 0, cnt_we = 0, wdt_en_opt = 1;
    logic [5:0] mode_wdata = '0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_value;
    logic       wdt_rst, tof_flag;

    int    checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    bit    started = 0;

    // Behavioural reference state.
    int m_s1 = 0, m_s2 = 0, m_d = 0, m_mode = 63, m_psc = 0, m_cnt = 0;
    int m_wdt = 0, m_flag = 1, m_rst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_wdog_top #(.WDT_W(WDT_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .sleep_req(sleep_req),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .wdt_en_opt(wdt_en_opt), .cnt_value(cnt_value),
        .wdt_rst(wdt_rst), .tof_flag(tof_flag)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_d = 0; m_mode = 63; m_psc = 0; m_cnt = 0;
            m_wdt = 0; m_flag = 1; m_rst = 0;
        end else begin
            int to_w, div, evt, src, pin_in, pout, kick, tinc, wt;
            to_w   = (m_mode >> 3) & 1;
            div    = to_w ? (1 << (m_mode & 7)) : (1 << ((m_mode & 7) + 1));
            evt    = ((m_mode >> 4) & 1) ? (m_d && !m_s2) : (!m_d && m_s2);
            src    = ((m_mode >> 5) & 1) ? evt : int'(cyc_tick);
            pin_in = to_w ? int'(wdt_tick) : src;
            pout   = pin_in && (m_psc == div - 1);
            kick   = wdt_clr || sleep_req;
            tinc   = to_w ? src : pout;
            wt     = to_w ? pout : int'(wdt_tick);
            if ((cnt_we && !to_w) || (kick && to_w)) m_psc = 0;
            else if (pin_in) m_psc = (m_psc == div - 1) ? 0 : m_psc + 1;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (tinc) m_cnt = (m_cnt + 1) % 256;
            m_rst = 0;
            if (kick) begin m_wdt = 0; m_flag = 1; end
            else if (!wdt_en_opt) m_wdt = 0;
            else if (wt) begin
                if (m_wdt == (1 << WDT_BITS) - 1) begin m_wdt = 0; m_flag = 0; m_rst = 1; end
                else m_wdt = m_wdt + 1;
            end
            if (mode_we) m_mode = mode_wdata;
            m_d = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) if (started) begin
        checks++;
        if (cnt_value != 8'(m_cnt) || wdt_rst != 1'(m_rst) || tof_flag != 1'(m_flag)) begin
            fails++;
            $display("FAIL %s: actual cnt=%0d rst=%0d flag=%0d expected cnt=%0d rst=%0d flag=%0d",
                     cur_req, cnt_value, wdt_rst, tof_flag, m_cnt, m_rst, m_flag);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(logic [5:0] v);
        @(negedge clk); mode_we = 1; mode_wdata = v;
        @(negedge clk); mode_we = 0;
    endtask

    task automatic wr_cnt(logic [7:0] v);
        @(negedge clk); cnt_we = 1; cnt_wdata = v;
        @(negedge clk); cnt_we = 0;
    endtask

    initial begin
        int pulses;
        cyc(3);
        cur_req = "R1";
        chk("R1 cnt", cnt_value, 0); chk("R1 flag", tof_flag, 1); chk("R1 rst", wdt_rst, 0);
        @(negedge clk); rst_n = 1;

        cur_req = "R2";
        wr_mode(6'b001000);
        cyc_tick = 1; cyc(5); cyc_tick = 0; cyc(1);
        chk("R2 direct count", cnt_value, 5);

        cur_req = "R7";
        cnt_we = 1; cnt_wdata = 8'h40; cyc_tick = 1; cyc(1);
        cnt_we = 0; cyc_tick = 0; cyc(1);
        chk("R7 write wins", cnt_value, 8'h40);

        cur_req = "R3";
        wr_mode(6'b000010);
        wr_cnt(8'h00);
        cyc_tick = 1; cyc(32); cyc_tick = 0; cyc(1);
        chk("R3 divide by 8", cnt_value, 4);
        wr_mode(6'b000111);
        wr_cnt(8'h00);
        cyc_tick = 1; cyc(300); cyc_tick = 0; cyc(1);
        chk("R3 divide by 256", cnt_value, 1);

        cur_req = "R6";
        wr_mode(6'b001000);
        wr_cnt(8'hFE);
        cyc_tick = 1; cyc(3); cyc_tick = 0; cyc(1);
        chk("R6 wrap", cnt_value, 1);

        cur_req = "R5";
        wr_mode(6'b101000);
        wr_cnt(8'h00);
        for (int i = 0; i < 3; i++) begin ext_pin = 1; cyc(4); ext_pin = 0; cyc(4); end
        chk("R5 rising edges", cnt_value, 3);
        wr_mode(6'b111000);
        wr_cnt(8'h00);
        for (int i = 0; i < 3; i++) begin ext_pin = 1; cyc(4); ext_pin = 0; cyc(4); end
        chk("R5 falling edges", cnt_value, 3);

        cur_req = "R4";
        wr_mode(6'b001001);
        @(negedge clk); wdt_clr = 1; @(negedge clk); wdt_clr = 0;
        wdt_tick = 1; pulses = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (wdt_rst) pulses++; end
        wdt_tick = 0;
        cur_req = "R9";
        chk("R9 one overflow pulse", pulses, 1);
        chk("R9 flag dropped", tof_flag, 0);

        cur_req = "R8";
        @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0; cyc(1);
        chk("R8 flag restored", tof_flag, 1);

        cur_req = "R10";
        wdt_en_opt = 0; wdt_tick = 1; pulses = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (wdt_rst) pulses++; end
        wdt_tick = 0;
        chk("R10 no reset when disabled", pulses, 0);
        chk("R10 flag kept", tof_flag, 1);

        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog on the bench itself.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule